// File: doc/BRIEF.md
# FSK Carrier Detect and Data Gating

This block sits behind a 1200 bit/s FSK demodulator (marks at 1200 Hz, spaces at 2200 Hz) in a caller-information receiver. It takes a raw carrier-energy flag and the demodulated bit stream. It produces an active-low carrier-detect flag, and two gated copies of the bit stream: a raw copy and a cooked copy. The carrier flag is debounced in both directions, counted in millisecond ticks that arrive on an input. A short loss of energy is bridged by a hold-over, so a brief gap in the carrier does not cut a message in two.

The raw copy passes every demodulated bit while carrier is detected. That includes the alternating 0/1 preamble and the mark run that follows it. The cooked copy opens only after a qualifier has seen a long enough alternating run followed by a long enough run of marks. The preamble is therefore stripped, and the downstream UART sees only the mark run and the characters. A bit-centre strobe input tells the qualifier when to sample. Both data outputs rest at 1 (mark) whenever they are closed.

Top module: `fsk_cd_gate`

## Requirements
- R1: After a synchronous active-low reset, cd_n, raw_out and cooked_out are all 1.
- R2: With carrier undetected, cd_n falls after ACQ_MS (default 14) ms_tick cycles during which energy_in is 1. Any cycle with energy_in at 0 restarts this count. The counter is updated on the clock edge that samples the tick, and cd_n changes on the edge of the ACQ_MS-th tick.
- R3: While carrier is detected and energy_in is 1, cd_n stays 0.
- R4: With carrier detected, cd_n rises on the edge of the HOLD_MS-th (default 8) ms_tick counted while energy_in is 0. A cycle with energy_in at 1 clears this count, so a dropout that lasts fewer than HOLD_MS ticks never releases carrier-detect.
- R5: raw_out is registered. On each edge it takes the value of demod_bit if cd_n was 0 before that edge, and 1 otherwise.
- R6: The qualifier samples demod_bit only on cycles where bit_stb is 1 and carrier is detected. It tracks the length of the current alternating run: the first sample has length 1, a sample that differs from the previous one adds 1, and a sample equal to the previous one restarts the length at 1. Once the length reaches ALT_MIN (default 16), this is remembered until the qualifier is cleared.
- R7: After an alternating run has been remembered, each later sampled 1 extends a mark count and each sampled 0 resets it to 0. The sample that brings the count to MARK_MIN (default 10) marks the stream as validated.
- R8: cooked_out is registered. On each edge it takes demod_bit if, before that edge, carrier was detected and the stream was validated, and 1 otherwise. The alternating preamble never appears on it.
- R9: All qualifier state (run length, remembered run, mark count, validation) clears while carrier is undetected. After a new acquisition, the cooked output stays closed until a fresh preamble and mark run have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bit_stb | input | 1 | One-cycle pulse at the centre of each received bit |
| energy_in | input | 1 | Raw in-band carrier energy present |
| demod_bit | input | 1 | Demodulated bit, 1 = mark, 0 = space |
| cd_n | output | 1 | Carrier detect, low while a carrier is valid |
| raw_out | output | 1 | Gated demodulator stream including preamble, idles 1 |
| cooked_out | output | 1 | Gated stream after preamble validation, idles 1 |

## Verification
cd_n comes straight from the debounce state register. It therefore changes on the same edge that samples the deciding tick, and it is read at the following falling edge. raw_out and cooked_out sit one register further on, so each of them reflects demod_bit and the gate state as they stood just before the edge that loads it. The bench therefore waits one full clock after a bit is strobed before it reads the gated value. A cycle-level reference built from the requirements is compared with all three outputs on every clock, one time unit after the edge. Directed checks are placed on cycles counted out from the tick and strobe tasks.

// File: rtl/fsk_gate_pkg.sv
// Shared types for the carrier-detect and data-gating block.
package fsk_gate_pkg;
    // Debounce state: no carrier, or carrier locked (possibly in hold-over).
    typedef enum logic {
        CD_IDLE   = 1'b0,
        CD_LOCKED = 1'b1
    } cd_state_t;

    // Index of each gated data channel.
    localparam int CH_RAW    = 0;
    localparam int CH_COOKED = 1;
    localparam int CH_NUM    = 2;
endpackage

// File: rtl/fsk_cd_debounce.sv
// Carrier debounce. It turns a raw energy flag into a clean carrier state.
// Acquisition needs ACQ_MS ticks in a row with energy present. Release needs
// HOLD_MS ticks in a row with energy absent.
// Assumes ms_tick is a single-cycle pulse, synchronous to clk.
module fsk_cd_debounce
    import fsk_gate_pkg::*;
#(
    parameter int ACQ_MS  = 14,
    parameter int HOLD_MS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic energy_in,
    output logic cd_active
);
    localparam int ACQ_W  = $clog2(ACQ_MS + 1);
    localparam int HOLD_W = $clog2(HOLD_MS + 1);
    localparam logic [ACQ_W-1:0]  ACQ_LAST  = ACQ_W'(ACQ_MS - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_MS - 1);

    cd_state_t          state;
    logic [ACQ_W-1:0]   acq_cnt;
    logic [HOLD_W-1:0]  hold_cnt;

    // Acquisition and hold-over counting, with state change at the limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CD_IDLE;
            acq_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            case (state)
                CD_IDLE: begin
                    if (!energy_in) begin
                        acq_cnt <= '0;
                    end else if (ms_tick) begin
                        if (acq_cnt == ACQ_LAST) begin
                            state    <= CD_LOCKED;
                            acq_cnt  <= '0;
                            hold_cnt <= '0;
                        end else begin
                            acq_cnt <= acq_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (energy_in) begin
                        hold_cnt <= '0;
                    end else if (ms_tick) begin
                        if (hold_cnt == HOLD_LAST) begin
                            state    <= CD_IDLE;
                            hold_cnt <= '0;
                        end else begin
                            hold_cnt <= hold_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Carrier is present in the locked state, hold-over included.
    assign cd_active = (state == CD_LOCKED);
endmodule

// File: rtl/fsk_preamble_qual.sv
// Preamble qualifier. It sees an alternating run of at least ALT_MIN bits,
// then a run of MARK_MIN marks, and raises 'validated'.
// Assumes bit_stb marks the bit centre. All state clears while carrier is absent.
module fsk_preamble_qual #(
    parameter int ALT_MIN  = 16,
    parameter int MARK_MIN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_active,
    input  logic bit_stb,
    input  logic demod_bit,
    output logic validated
);
    localparam int ALT_W  = $clog2(ALT_MIN + 1);
    localparam int MARK_W = $clog2(MARK_MIN + 1);
    localparam logic [ALT_W-1:0]  ALT_TOP  = ALT_W'(ALT_MIN);
    localparam logic [MARK_W-1:0] MARK_TOP = MARK_W'(MARK_MIN);

    logic              have_prev;
    logic              prev_bit;
    logic [ALT_W-1:0]  alt_len;
    logic [ALT_W-1:0]  alt_len_nxt;
    logic              alt_seen;
    logic [MARK_W-1:0] mark_len;
    logic [MARK_W-1:0] mark_len_nxt;

    // Next alternating-run length, saturating at the threshold.
    always_comb begin
        if (!have_prev || (demod_bit == prev_bit))
            alt_len_nxt = ALT_W'(1);
        else if (alt_len == ALT_TOP)
            alt_len_nxt = alt_len;
        else
            alt_len_nxt = alt_len + 1'b1;
    end

    // Next mark-run length, saturating at the threshold.
    always_comb begin
        if (!demod_bit)
            mark_len_nxt = '0;
        else if (mark_len == MARK_TOP)
            mark_len_nxt = mark_len;
        else
            mark_len_nxt = mark_len + 1'b1;
    end

    // Sequence tracking on each strobed bit, cleared when carrier is absent.
    always_ff @(posedge clk) begin
        if (!rst_n || !cd_active) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b1;
            alt_len   <= '0;
            alt_seen  <= 1'b0;
            mark_len  <= '0;
            validated <= 1'b0;
        end else if (bit_stb && !validated) begin
            have_prev <= 1'b1;
            prev_bit  <= demod_bit;
            alt_len   <= alt_len_nxt;
            if (alt_len_nxt == ALT_TOP)
                alt_seen <= 1'b1;
            if (alt_seen) begin
                mark_len <= mark_len_nxt;
                if (mark_len_nxt == MARK_TOP)
                    validated <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsk_out_gate.sv
// Output gating. Each channel registers the demodulated bit while its enable
// is set, and registers 1 (mark idle) otherwise.
// Assumes the enables are already registered.
module fsk_out_gate
    import fsk_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_NUM-1:0] ch_en,
    input  logic              demod_bit,
    output logic [CH_NUM-1:0] ch_q
);
    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        // One gated output register per channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ch_q[g] <= 1'b1;
            else
                ch_q[g] <= ch_en[g] ? demod_bit : 1'b1;
        end
    end
endmodule

// File: rtl/fsk_cd_gate.sv
// Top of the carrier-detect and data-gating block: debounce, preamble
// qualifier and the two gated data outputs.
// Assumes ms_tick and bit_stb are single-cycle pulses in the clk domain.
module fsk_cd_gate
    import fsk_gate_pkg::*;
#(
    parameter int ACQ_MS   = 14,
    parameter int HOLD_MS  = 8,
    parameter int ALT_MIN  = 16,
    parameter int MARK_MIN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic bit_stb,
    input  logic energy_in,
    input  logic demod_bit,
    output logic cd_n,
    output logic raw_out,
    output logic cooked_out
);
    logic              cd_active;
    logic              validated;
    logic [CH_NUM-1:0] ch_en;
    logic [CH_NUM-1:0] ch_q;

    fsk_cd_debounce #(.ACQ_MS(ACQ_MS), .HOLD_MS(HOLD_MS)) u_deb (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .energy_in(energy_in), .cd_active(cd_active)
    );

    fsk_preamble_qual #(.ALT_MIN(ALT_MIN), .MARK_MIN(MARK_MIN)) u_qual (
        .clk(clk), .rst_n(rst_n), .cd_active(cd_active),
        .bit_stb(bit_stb), .demod_bit(demod_bit), .validated(validated)
    );

    // Channel enables: raw needs carrier, cooked also needs validation.
    always_comb begin
        ch_en            = '0;
        ch_en[CH_RAW]    = cd_active;
        ch_en[CH_COOKED] = cd_active & validated;
    end

    fsk_out_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
        .demod_bit(demod_bit), .ch_q(ch_q)
    );

    assign cd_n       = ~cd_active;
    assign raw_out    = ch_q[CH_RAW];
    assign cooked_out = ch_q[CH_COOKED];
endmodule

// File: rtl/fsk_cd_gate_chk.sv
// Port-level checker for fsk_cd_gate, attached with bind.
module fsk_cd_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic energy_in,
    input logic demod_bit,
    input logic cd_n,
    input logic raw_out,
    input logic cooked_out
);
    AST_CD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_n && energy_in) |=> !cd_n); // R3
    AST_CD_ACQ_ENERGY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> $past(energy_in)); // R2
    AST_RAW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cd_n |=> (raw_out == $past(demod_bit))); // R5
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cd_n |=> (raw_out && cooked_out)); // R5
    AST_COOKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        !cooked_out |-> !raw_out); // R8
endmodule

bind fsk_cd_gate fsk_cd_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .energy_in(energy_in), .demod_bit(demod_bit),
    .cd_n(cd_n), .raw_out(raw_out), .cooked_out(cooked_out)
);

// File: tb/sim_fsk_cd_gate.sv
// Bench for fsk_cd_gate: directed corner cases, then seeded random stimulus,
// compared every cycle against a reference written from the requirements.
module sim_fsk_cd_gate;
    localparam int CLK_PERIOD = 10;
    localparam int ACQ  = 14;
    localparam int HOLD = 8;
    localparam int ALTN = 16;
    localparam int MRKN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, bit_stb = 1'b0, energy_in = 1'b0, demod_bit = 1'b1;
    logic cd_n, raw_out, cooked_out;
    int n_chk = 0, n_bad = 0;
    logic run_cmp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_cd_gate u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bit_stb(bit_stb),
        .energy_in(energy_in), .demod_bit(demod_bit),
        .cd_n(cd_n), .raw_out(raw_out), .cooked_out(cooked_out)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: R2/R4 carrier, R6/R7/R9 qualifier, R5/R8 outputs.
    logic m_cd; int m_acq, m_hold;
    logic m_have, m_prev, m_altok, m_valid; int m_alt, m_mark;
    logic m_raw, m_cooked;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cd <= 0; m_acq <= 0; m_hold <= 0;
            m_have <= 0; m_prev <= 1; m_alt <= 0; m_altok <= 0; m_mark <= 0; m_valid <= 0;
            m_raw <= 1; m_cooked <= 1;
        end else begin
            m_raw    <= m_cd ? demod_bit : 1'b1;
            m_cooked <= (m_cd && m_valid) ? demod_bit : 1'b1;
            if (!m_cd) begin
                if (!energy_in) m_acq <= 0;
                else if (ms_tick) begin
                    if (m_acq + 1 >= ACQ) begin m_cd <= 1; m_acq <= 0; m_hold <= 0; end
                    else m_acq <= m_acq + 1;
                end
            end else begin
                if (energy_in) m_hold <= 0;
                else if (ms_tick) begin
                    if (m_hold + 1 >= HOLD) begin m_cd <= 0; m_hold <= 0; end
                    else m_hold <= m_hold + 1;
                end
            end
            if (!m_cd) begin
                m_have <= 0; m_prev <= 1; m_alt <= 0; m_altok <= 0; m_mark <= 0; m_valid <= 0;
            end else if (bit_stb && !m_valid) begin
                int na, nm;
                na = (!m_have || demod_bit == m_prev) ? 1 : m_alt + 1;
                m_have <= 1; m_prev <= demod_bit; m_alt <= na;
                if (na >= ALTN) m_altok <= 1;
                if (m_altok) begin
                    nm = demod_bit ? m_mark + 1 : 0;
                    m_mark <= nm;
                    if (nm >= MRKN) m_valid <= 1;
                end
            end
        end
    end

    // Per-cycle comparison one time unit after the edge.
    always @(posedge clk) begin
        #1;
        if (run_cmp) begin
            chk("R2/R4 cd_n vs model", cd_n, ~m_cd);
            chk("R5 raw_out vs model", raw_out, m_raw);
            chk("R8 cooked_out vs model", cooked_out, m_cooked);
        end
    end

    task automatic tick_ms(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk) demod_bit = b;
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_alt(int n);
        for (int i = 0; i < n; i++) send_bit(logic'(i % 2));
    endtask

    task automatic send_marks(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5447));
        repeat (3) @(negedge clk);
        chk("R1 cd_n reset", cd_n, 1'b1);
        chk("R1 raw reset", raw_out, 1'b1);
        chk("R1 cooked reset", cooked_out, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        run_cmp = 1'b1;

        // R2: a gap in energy restarts acquisition.
        energy_in = 1'b1; tick_ms(10);
        @(negedge clk) energy_in = 1'b0;
        @(negedge clk) energy_in = 1'b1;
        tick_ms(ACQ - 1);
        chk("R2 cd_n one tick short", cd_n, 1'b1);
        tick_ms(1);
        chk("R2 cd_n after full count", cd_n, 1'b0);

        // R4: a dropout shorter than the hold-over, then one as long as it.
        energy_in = 1'b0; tick_ms(HOLD - 1);
        chk("R4 short dropout keeps cd_n", cd_n, 1'b0);
        energy_in = 1'b1; tick_ms(1);
        energy_in = 1'b0; tick_ms(HOLD - 1);
        chk("R4 hold count cleared by energy", cd_n, 1'b0);
        tick_ms(1);
        chk("R4 release after hold-over", cd_n, 1'b1);
        send_bit(1'b0);
        chk("R5 raw idles high without carrier", raw_out, 1'b1);

        // R6: broken alternation must not qualify.
        energy_in = 1'b1; tick_ms(ACQ);
        send_alt(12); send_bit(1'b1); send_alt(12);
        send_marks(MRKN); send_bit(1'b0);
        chk("R6 broken alternation keeps cooked closed", cooked_out, 1'b1);
        chk("R5 raw passes space", raw_out, 1'b0);
        chk("R3 cd_n held with energy", cd_n, 1'b0);

        // R7: an interrupted mark run, then a full one.
        send_alt(ALTN); send_marks(MRKN - 1); send_bit(1'b0);
        chk("R8 preamble not on cooked", cooked_out, 1'b1);
        send_marks(MRKN - 1); send_bit(1'b0);
        chk("R7 short mark run keeps cooked closed", cooked_out, 1'b1);
        send_marks(MRKN); send_bit(1'b0);
        chk("R7 cooked opens after mark run", cooked_out, 1'b0);
        send_bit(1'b1);
        chk("R8 cooked follows mark", cooked_out, 1'b1);

        // R9: carrier loss clears validation.
        energy_in = 1'b0; tick_ms(HOLD);
        chk("R9 cooked idle after loss", cooked_out, 1'b1);
        energy_in = 1'b1; tick_ms(ACQ);
        send_marks(MRKN); send_bit(1'b0);
        chk("R9 cooked closed after reacquire", cooked_out, 1'b1);
        chk("R5 raw open after reacquire", raw_out, 1'b0);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) begin
                @(negedge clk) energy_in = ~energy_in;
            end else if (r < 5) begin
                tick_ms(1);
            end else if (r == 5) begin
                send_alt(ALTN + $urandom_range(0, 4));
                send_marks(MRKN + $urandom_range(0, 2));
            end else begin
                send_bit(logic'($urandom_range(0, 1)));
            end
        end

        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule